// File: doc/BRIEF.md
# Interleaved Vector Element Load/Store Sequencer

This block runs one multi-register element transfer between a 64-bit register file and byte-addressed memory. A start pulse supplies a layout code, an element size, a five-bit first register index, a base address and a direction bit. The sequencer then issues one memory access at a time on a request/acknowledge port. On a load it assembles each register from its elements and writes it back. On a store it reads the register and sends out its elements one by one.

The layout code selects three values: how many registers take part, the interleave factor, and the register index step. These values set the address pattern. Within a register, successive elements lie `element size × interleave` bytes apart. Between registers, the address either continues from where it stopped, restarts at a per-register offset from the base, or jumps back once to the second element slot. The register file and the memory sit outside the block.

Top module: `vls_seq`

## Requirements
- R1: A start with layout code 11 to 15 raises `err_o` for exactly the cycle after the start edge. It issues no memory request and no write-back, and it does not assert `done_o` or `busy_o`.
- R2: Layout codes 0 to 10 map to (registers, interleave, step) as follows: 0:(4,4,1) 1:(4,4,2) 2:(4,1,1) 3:(4,2,1) 4:(3,3,1) 5:(3,3,2) 6:(3,1,1) 7:(1,1,1) 8:(2,2,1) 9:(2,2,2) 10:(2,1,1). The first register is `{reg_hi_i, reg_lo_i}`. Each following register index adds the step, modulo 32.
- R3: Each register takes 8, 4, 2 or 1 accesses for size code 0, 1, 2 or 3. An element is `1<<size` bytes wide, and `mem_size_o` carries the size code during every access.
- R4: Within a register, each access address is the previous one plus element bytes × interleave. The first access of an operation goes to the base address. Address arithmetic wraps at the address width.
- R5: When the interleave exceeds 2, or when interleave is 2 with two registers, register r (counted from 0) starts at base + element bytes × r.
- R6: With interleave 2 and four registers, register 2 starts at base + element bytes. For registers that no rule in R5 or R6 covers, the address continues by one more stride from the last access of the previous register.
- R7: On a load, element i of a register fills bits [i·8·bytes +: 8·bytes] of the register (little-endian). The register is written through `rf_we_o`/`rf_waddr_o`/`rf_wdata_o` for one cycle, in the cycle after the register's last acknowledged access.
- R8: On a store, `mem_we_o` is high with every request. `mem_wdata_o` carries element i of the register addressed by `rf_raddr_o`, right-aligned and zero-extended. No write-back occurs.
- R9: A request keeps its address, direction and data stable until it is acknowledged. The next access may be requested in the cycle right after the acknowledge.
- R10: `busy_o` is high from the cycle after an accepted start until the final register step. `done_o` pulses exactly once, in that final step cycle.
- R11: A start pulse while `busy_o` is high is ignored. It does not raise `err_o` and does not disturb the running access sequence.
- R12: While reset is asserted, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| type_i | input | 4 | Layout code |
| size_i | input | 2 | Element size code (bytes = 1<<size) |
| reg_lo_i | input | RW-1 | Low bits of first register index |
| reg_hi_i | input | 1 | High bit of first register index |
| base_i | input | AW | Base byte address |
| load_i | input | 1 | 1 = load, 0 = store |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Final step pulse |
| err_o | output | 1 | Rejected layout code pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Request is a write |
| mem_size_o | output | 2 | Element size code of the access |
| mem_addr_o | output | AW | Access byte address |
| mem_wdata_o | output | DW | Store element, right-aligned |
| mem_ack_i | input | 1 | Access accepted/complete |
| mem_rdata_i | input | DW | Load element, right-aligned |
| rf_raddr_o | output | RW | Register read index for stores |
| rf_rdata_i | input | DW | Register read data |
| rf_we_o | output | 1 | Register write-back strobe |
| rf_waddr_o | output | RW | Register write-back index |
| rf_wdata_o | output | DW | Packed register value |

## Verification
A wrong address-generator state first shows up on the address of the next request after an acknowledge. The break points between registers are where R5 and R6 differ from plain continuation, so the bench compares every request address on every cycle. A wrong element counter or packing offset shows up as a wrong write-back value or register index one cycle after the last access of a register, or as a wrong store element on the very next request. State-machine faults show up as an extra or missing request, a missing `done_o`, or a late `busy_o` fall within a cycle of the expected end.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int unsigned NUM_LAYOUTS = 11;

  typedef struct packed {
    logic [2:0] nregs;
    logic [2:0] ilv;
    logic [1:0] spc;
  } layout_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_STEP = 2'd2
  } state_e;

  function automatic layout_t layout_lookup(input logic [3:0] code);
    layout_t l;
    case (code)
      4'd0:    l = '{nregs: 3'd4, ilv: 3'd4, spc: 2'd1};
      4'd1:    l = '{nregs: 3'd4, ilv: 3'd4, spc: 2'd2};
      4'd2:    l = '{nregs: 3'd4, ilv: 3'd1, spc: 2'd1};
      4'd3:    l = '{nregs: 3'd4, ilv: 3'd2, spc: 2'd1};
      4'd4:    l = '{nregs: 3'd3, ilv: 3'd3, spc: 2'd1};
      4'd5:    l = '{nregs: 3'd3, ilv: 3'd3, spc: 2'd2};
      4'd6:    l = '{nregs: 3'd3, ilv: 3'd1, spc: 2'd1};
      4'd7:    l = '{nregs: 3'd1, ilv: 3'd1, spc: 2'd1};
      4'd8:    l = '{nregs: 3'd2, ilv: 3'd2, spc: 2'd1};
      4'd9:    l = '{nregs: 3'd2, ilv: 3'd2, spc: 2'd2};
      4'd10:   l = '{nregs: 3'd2, ilv: 3'd1, spc: 2'd1};
      default: l = '{nregs: 3'd1, ilv: 3'd1, spc: 2'd1};
    endcase
    return l;
  endfunction
endpackage

// File: rtl/vls_decode.sv
module vls_decode
  import vls_pkg::*;
(
  input  logic [3:0] code_i,
  output layout_t    layout_o,
  output logic       valid_o
);
  assign layout_o = layout_lookup(code_i);
  assign valid_o  = code_i < 4'(NUM_LAYOUTS);
endmodule

// File: rtl/vls_addr_gen.sv
module vls_addr_gen #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic [AW-1:0] base_i,
  input  logic [1:0]    size_i,
  input  logic [2:0]    ilv_i,
  input  logic [2:0]    nregs_i,
  input  logic          step_i,
  input  logic          last_elem_i,
  input  logic [2:0]    next_reg_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, addr_d, base_q, esize, stride;
  logic          restart, mid_jump;

  assign esize    = AW'(1) << size_i;
  assign stride   = esize * AW'(ilv_i);
  // per-register restart vs. single jump back at register 2
  assign restart  = (ilv_i > 3'd2) || (ilv_i == 3'd2 && nregs_i == 3'd2);
  assign mid_jump = (ilv_i == 3'd2) && (nregs_i == 3'd4) && (next_reg_i == 3'd2);

  always_comb begin
    addr_d = addr_q;
    if (init_i) begin
      addr_d = base_i;
    end else if (step_i) begin
      if (last_elem_i && restart)       addr_d = base_q + esize * AW'(next_reg_i);
      else if (last_elem_i && mid_jump) addr_d = base_q + esize;
      else                              addr_d = addr_q + stride;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      base_q <= '0;
    end else begin
      addr_q <= addr_d;
      if (init_i) base_q <= base_i;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/vls_lane.sv
module vls_lane #(
  parameter int unsigned DW = 64
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        put_i,
  input  logic [1:0]                  size_i,
  input  logic [$clog2(DW/8)-1:0]     elem_i,
  input  logic [DW-1:0]               rdata_i,
  input  logic [DW-1:0]               reg_i,
  output logic [DW-1:0]               word_o,
  output logic [DW-1:0]               elem_o
);
  localparam int unsigned SHW = $clog2(DW);

  logic [DW-1:0]  mask, word_q;
  logic [SHW-1:0] sh;

  assign mask = (size_i == 2'd3) ? '1 : ((DW'(1) << (DW'(8) << size_i)) - DW'(1));
  assign sh   = SHW'(elem_i) << ({1'b0, size_i} + 3'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (clr_i)  word_q <= '0;
    else if (put_i)  word_q <= (word_q & ~(mask << sh)) | ((rdata_i & mask) << sh);
  end

  assign word_o = word_q;
  assign elem_o = (reg_i >> sh) & mask;
endmodule

// File: rtl/vls_seq.sv
module vls_seq
  import vls_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 64,
  parameter int unsigned RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    type_i,
  input  logic [1:0]    size_i,
  input  logic [RW-2:0] reg_lo_i,
  input  logic          reg_hi_i,
  input  logic [AW-1:0] base_i,
  input  logic          load_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [1:0]    mem_size_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [RW-1:0] rf_raddr_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o
);
  localparam int unsigned BYTES = DW / 8;
  localparam int unsigned EW    = $clog2(BYTES);

  state_e        state_q, state_d;
  layout_t       lay_dec, lay_q;
  logic          code_ok, accept, ack_x, last_elem, last_reg;
  logic [1:0]    size_q;
  logic          load_q, err_q;
  logic [RW-1:0] ridx_q;
  logic [2:0]    rcnt_q;
  logic [EW-1:0] elem_q, last_idx;
  logic [DW-1:0] word, elem_data;

  vls_decode i_decode (
    .code_i   (type_i),
    .layout_o (lay_dec),
    .valid_o  (code_ok)
  );

  assign accept    = (state_q == ST_IDLE) && start_i && code_ok;
  assign ack_x     = (state_q == ST_XFER) && mem_ack_i;
  assign last_idx  = EW'((BYTES >> size_q) - 1);
  assign last_elem = elem_q == last_idx;
  assign last_reg  = rcnt_q == (lay_q.nregs - 3'd1);

  vls_addr_gen #(.AW(AW)) i_addr_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (accept),
    .base_i      (base_i),
    .size_i      (size_q),
    .ilv_i       (lay_q.ilv),
    .nregs_i     (lay_q.nregs),
    .step_i      (ack_x),
    .last_elem_i (last_elem),
    .next_reg_i  (rcnt_q + 3'd1),
    .addr_o      (mem_addr_o)
  );

  vls_lane #(.DW(DW)) i_lane (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .put_i   (ack_x && load_q),
    .size_i  (size_q),
    .elem_i  (elem_q),
    .rdata_i (mem_rdata_i),
    .reg_i   (rf_rdata_i),
    .word_o  (word),
    .elem_o  (elem_data)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_XFER;
      ST_XFER: if (mem_ack_i && last_elem) state_d = ST_STEP;
      ST_STEP: state_d = last_reg ? ST_IDLE : ST_XFER;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lay_q   <= '0;
      size_q  <= '0;
      load_q  <= 1'b0;
      ridx_q  <= '0;
      rcnt_q  <= '0;
      elem_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= (state_q == ST_IDLE) && start_i && !code_ok;
      if (accept) begin
        lay_q  <= lay_dec;
        size_q <= size_i;
        load_q <= load_i;
        ridx_q <= {reg_hi_i, reg_lo_i};
        rcnt_q <= '0;
        elem_q <= '0;
      end else if (ack_x && !last_elem) begin
        elem_q <= elem_q + EW'(1);
      end else if (state_q == ST_STEP && !last_reg) begin
        rcnt_q <= rcnt_q + 3'd1;
        ridx_q <= ridx_q + RW'(lay_q.spc);
        elem_q <= '0;
      end
    end
  end

  assign busy_o      = state_q != ST_IDLE;
  assign done_o      = (state_q == ST_STEP) && last_reg;
  assign err_o       = err_q;
  assign mem_req_o   = state_q == ST_XFER;
  assign mem_we_o    = mem_req_o && !load_q;
  assign mem_size_o  = mem_req_o ? size_q : 2'd0;
  assign mem_wdata_o = mem_we_o ? elem_data : '0;
  assign rf_raddr_o  = ridx_q;
  assign rf_we_o     = (state_q == ST_STEP) && load_q;
  assign rf_waddr_o  = rf_we_o ? ridx_q : '0;
  assign rf_wdata_o  = rf_we_o ? word : '0;
endmodule

// File: rtl/vls_seq_chk.sv
module vls_seq_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 64,
  parameter int unsigned RW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [1:0]    mem_size_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ack_i,
  input logic          rf_we_o
);
  assert_err_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !mem_req_o && !busy_o && !rf_we_o && !done_o);

  assert_size_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && $past(mem_req_o) && $past(busy_o) |-> $stable(mem_size_o));

  assert_wb_apart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> !mem_req_o);

  assert_we_in_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  assert_req_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  assert_no_err_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !err_o);
endmodule

bind vls_seq vls_seq_chk #(.AW(AW), .DW(DW), .RW(RW)) i_chk (.*);

// File: tb/test_vls_seq.sv
module test_vls_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  type_i = '0;
  logic [1:0]  size_i = '0;
  logic [3:0]  reg_lo_i = '0;
  logic        reg_hi_i = 1'b0;
  logic [31:0] base_i = '0;
  logic        load_i = 1'b0;
  logic        busy_o, done_o, err_o, mem_req_o, mem_we_o, rf_we_o;
  logic [1:0]  mem_size_o;
  logic [31:0] mem_addr_o;
  logic [63:0] mem_wdata_o, rf_rdata_i, rf_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic [4:0]  rf_raddr_o, rf_waddr_o;

  logic [63:0] rf_model [32];
  logic [31:0] q_addr[$];
  string       q_tag[$];
  logic [63:0] q_wd[$];
  logic [4:0]  q_wba[$];
  logic [63:0] q_wbd[$];
  logic        cur_load = 1'b0;
  logic [1:0]  cur_size = '0;
  int          n_checks = 0, n_err = 0, ack_ctr = 0;
  logic        prev_req = 1'b0, prev_ack = 1'b0;
  logic [31:0] prev_addr = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vls_seq i_vls_seq (.*);

  assign rf_rdata_i = rf_model[rf_raddr_o];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ a[31:24] ^ 8'hA7;
  endfunction

  function automatic logic [63:0] mem_elem(input logic [31:0] a, input int nb);
    logic [63:0] v = '0;
    for (int k = 0; k < nb; k++) v[k*8 +: 8] = mem_byte(a + 32'(k));
    return v;
  endfunction

  task automatic build(input int t, input int sz, input int rd, input logic [31:0] base,
                       input bit ld);
    int nr, il, sp, es, nel, r;
    logic [31:0] a;
    logic [63:0] word, mask;
    case (t)
      0: begin nr = 4; il = 4; sp = 1; end
      1: begin nr = 4; il = 4; sp = 2; end
      2: begin nr = 4; il = 1; sp = 1; end
      3: begin nr = 4; il = 2; sp = 1; end
      4: begin nr = 3; il = 3; sp = 1; end
      5: begin nr = 3; il = 3; sp = 2; end
      6: begin nr = 3; il = 1; sp = 1; end
      7: begin nr = 1; il = 1; sp = 1; end
      8: begin nr = 2; il = 2; sp = 1; end
      9: begin nr = 2; il = 2; sp = 2; end
      default: begin nr = 2; il = 1; sp = 1; end
    endcase
    es   = 1 << sz;
    nel  = 8 / es;
    mask = (es == 8) ? '1 : ((64'd1 << (es * 8)) - 64'd1);
    a    = base;
    r    = rd;
    for (int g = 0; g < nr; g++) begin
      string tg = "R4";
      if (il > 2 || (il == 2 && nr == 2)) begin
        a = base + 32'(es * g);
        if (g > 0) tg = "R5";
      end else if (il == 2 && nr == 4 && g == 2) begin
        a = base + 32'(es);
        tg = "R6";
      end else if (g > 0) begin
        tg = "R6";
      end
      word = '0;
      for (int e = 0; e < nel; e++) begin
        q_addr.push_back(a);
        q_tag.push_back(e == 0 ? tg : "R4");
        if (ld) word |= mem_elem(a, es) << (e * es * 8);
        else    q_wd.push_back((rf_model[r] >> (e * es * 8)) & mask);
        a = a + 32'(es * il);
      end
      if (ld) begin
        q_wba.push_back(5'(r));
        q_wbd.push_back(word);
      end
      r = (r + sp) % 32;
    end
  endtask

  // reference memory, request and write-back comparison on every cycle
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_req && !prev_ack && mem_req_o)
        chk(mem_addr_o == prev_addr, "R9", "held address", 64'(mem_addr_o), 64'(prev_addr));
      mem_ack_i = 1'b0;
      if (mem_req_o) begin
        if (q_addr.size() == 0) begin
          chk(1'b0, "R1", "request with none expected", 64'(mem_addr_o), 64'd0);
        end else begin
          chk(mem_addr_o == q_addr[0], q_tag[0], "address", 64'(mem_addr_o), 64'(q_addr[0]));
          chk(mem_size_o == cur_size, "R3", "access size", 64'(mem_size_o), 64'(cur_size));
          chk(mem_we_o == !cur_load, "R8", "direction", 64'(mem_we_o), 64'(!cur_load));
          if (!cur_load)
            chk(mem_wdata_o == q_wd[0], "R8", "store element", mem_wdata_o, q_wd[0]);
          if ((ack_ctr % 3) != 2) begin
            mem_ack_i   = 1'b1;
            mem_rdata_i = mem_elem(mem_addr_o, 1 << mem_size_o);
            void'(q_addr.pop_front());
            void'(q_tag.pop_front());
            if (!cur_load) void'(q_wd.pop_front());
          end
          ack_ctr++;
        end
      end
      if (rf_we_o) begin
        if (q_wba.size() == 0) begin
          chk(1'b0, "R7", "unexpected write-back", 64'(rf_waddr_o), 64'd0);
        end else begin
          chk(rf_waddr_o == q_wba[0], "R2", "write-back index", 64'(rf_waddr_o), 64'(q_wba[0]));
          chk(rf_wdata_o == q_wbd[0], "R7", "packed register", rf_wdata_o, q_wbd[0]);
          rf_model[q_wba[0]] = q_wbd[0];
          void'(q_wba.pop_front());
          void'(q_wbd.pop_front());
        end
      end
      prev_req  = mem_req_o;
      prev_ack  = mem_ack_i;
      prev_addr = mem_addr_o;
    end
  end

  task automatic run_op(input int t, input int sz, input int rd, input logic [31:0] base,
                        input bit ld, input bit poke);
    int n = 0;
    build(t, sz, rd, base, ld);
    @(negedge clk_i);
    cur_load = ld;
    cur_size = 2'(sz);
    start_i  = 1'b1;
    type_i   = 4'(t);
    size_i   = 2'(sz);
    reg_lo_i = 4'(rd);
    reg_hi_i = rd[4];
    base_i   = base;
    load_i   = ld;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o, "R10", "busy after start", 64'(busy_o), 64'd1);
    if (poke) begin
      start_i = 1'b1;
      type_i  = 4'hF;
      load_i  = ~ld;
      @(negedge clk_i);
      start_i = 1'b0;
      chk(!err_o, "R11", "start while busy", 64'(err_o), 64'd0);
      @(negedge clk_i);
      chk(!err_o, "R11", "start while busy", 64'(err_o), 64'd0);
    end
    while (!done_o && n < 2000) begin
      @(negedge clk_i);
      n++;
    end
    chk(done_o, "R10", "done pulse", 64'(done_o), 64'd1);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R10", "single done then idle", 64'({done_o, busy_o}), 64'd0);
    chk(q_addr.size() == 0, "R2", "accesses left over", 64'(q_addr.size()), 64'd0);
    chk(q_wba.size() == 0, "R7", "write-backs left over", 64'(q_wba.size()), 64'd0);
  endtask

  task automatic bad_op(input int t);
    @(negedge clk_i);
    start_i = 1'b1;
    type_i  = 4'(t);
    load_i  = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(err_o, "R1", "error pulse", 64'(err_o), 64'd1);
    chk(!busy_o, "R1", "not busy on reject", 64'(busy_o), 64'd0);
    @(negedge clk_i);
    chk(!err_o, "R1", "error one cycle", 64'(err_o), 64'd0);
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !rf_we_o, "R1", "stays idle", 64'({busy_o, done_o, rf_we_o}), 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "R10", "watchdog expired", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++)
      rf_model[i] = (64'h0123_4567_89AB_CDEF * 64'(i + 1)) ^ {32'(i), 32'hF00D_0000 | 32'(i)};
    repeat (2) @(negedge clk_i);
    chk({busy_o, done_o, err_o, mem_req_o, mem_we_o, rf_we_o} == 6'd0, "R12", "reset outputs",
        64'({busy_o, done_o, err_o, mem_req_o, mem_we_o, rf_we_o}), 64'd0);
    chk(mem_addr_o == '0 && mem_wdata_o == '0 && rf_wdata_o == '0, "R12", "reset data",
        64'(mem_addr_o), 64'd0);
    rst_ni = 1'b1;

    for (int t = 0; t < 11; t++)
      for (int sz = 0; sz < 4; sz++)
        for (int ld = 1; ld >= 0; ld--)
          run_op(t, sz, (t * 5 + sz * 9 + ld * 13) % 32,
                 32'h0000_2000 + 32'(t * 256 + sz * 16 + ld * 3), ld[0], 1'b0);

    run_op(1, 0, 30, 32'h0000_4000, 1'b1, 1'b0);  // R2 index wrap past 31
    run_op(1, 1, 30, 32'h0000_4100, 1'b0, 1'b0);
    run_op(3, 2, 17, 32'hFFFF_FFF4, 1'b1, 1'b0);  // R4 address wrap
    run_op(0, 0, 4, 32'h0000_5000, 1'b1, 1'b1);   // R11 start while busy
    run_op(2, 1, 9, 32'h0000_5200, 1'b0, 1'b1);

    bad_op(11);
    bad_op(15);
    run_op(7, 3, 31, 32'h0000_6008, 1'b1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule